// File: doc/BRIEF.md
# Column-Scan Dot-Matrix Character Generator

This block turns a 6-bit character code into a 5x7 dot-matrix glyph and presents it one column at a time on seven dot outputs. A column sequencer walks through the five glyph columns from left to right, then through one or two blank spacing columns, and then wraps back to the leftmost column. Each advance is triggered by a single-cycle step pulse.

A sync flag is raised while the sequencer sits on the final spacing column. An outside register can use it to load the next character code. The glyph store is read combinationally, so a new code appears on the outputs without any step. Three controls shape the output:
- A blank input forces every dot to the off level without disturbing the sequencer.
- An output enable releases the dot lines for wire-OR use.
- A sequence restart input parks the sequencer on the final spacing column, so the next step starts a fresh character.

Top module: `charcol_gen`

## Requirements
- R1: In a glyph column c (0..4) with the outputs enabled and not blanked, `dots` shows the column pattern g = (code*11 + c*29 + 5) mod 128. A lit dot is driven 0, so `dots` = ~g. Bit i of g is row i.
- R2: Each `col_step` pulse advances the sequencer by one column, starting at glyph column 0. After the final spacing column it wraps to glyph column 0.
- R3: With `two_space`=1 there are two spacing columns (a 7-step cycle). With `two_space`=0 there is one spacing column (a 6-step cycle).
- R4: In every spacing column, `dots` is 7'h7F (all dots off).
- R5: `seq_restart` puts the sequencer on the final spacing column, so the first step after it shows glyph column 0.
- R6: `col_last` is 1 only while the sequencer is on the final spacing column.
- R7: `blank`=1 forces `dots` to 7'h7F. The sequencer and `col_last` carry on unchanged.
- R8: With `out_en`=0, `dots_drive` is 0 and `dots` reads 7'h00 (released). With `out_en`=1, `dots_drive` is 1.
- R9: Changing `char_code` with no step changes `dots` in the same cycle, and the sequencer does not move.
- R10: When `seq_restart` and `col_step` are both high in a cycle, the restart wins. Without either, the sequencer holds its column.
- R11: After the active-low synchronous reset, the sequencer is on the final spacing column: `col_last`=1 and `dots`=7'h7F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| char_code | input | 6 | Character selector |
| col_step | input | 1 | One-cycle pulse that advances the column |
| seq_restart | input | 1 | Parks the sequencer on the final spacing column |
| two_space | input | 1 | 1: two spacing columns, 0: one spacing column |
| blank | input | 1 | Forces all dots off |
| out_en | input | 1 | Output enable; 0 releases the dot lines |
| dots | output | 7 | Column dots, active low (0 = lit) |
| dots_drive | output | 1 | 1 while the dot lines are driven |
| col_last | output | 1 | High on the final spacing column |

## Verification
The bench aims at the two spacing lengths: it switches between them across several characters. A sequencer that miscounts would show a glyph column where a blank is due, or raise `col_last` a column early or late. A restart that collides with a step would, in a flawed design, move one column too far. Code changes while the sequencer is idle would leave the outputs stale in a registered read path. Blanking in the middle of a character checks that blanking does not freeze or reset the sequence.

// File: rtl/chgen_pkg.sv
// Package: shared widths, column encoding and the computed glyph pattern.
// Assumes the glyph set is generated arithmetically (a test font).
package chgen_pkg;
    localparam int CODE_W  = 6;
    localparam int N_CHARS = 1 << CODE_W;
    localparam int N_GCOLS = 5;
    localparam int N_ROWS  = 7;
    localparam int COL_W   = 3;

    typedef logic [COL_W-1:0]  col_t;
    typedef logic [N_ROWS-1:0] row_t;

    // Column encoding: 0..4 glyph, 5 first spacing, 6 final spacing
    localparam col_t COL_SP1  = col_t'(N_GCOLS);
    localparam col_t COL_LAST = col_t'(N_GCOLS + 1);

    // Lit-dot pattern of glyph k, column c (1 = lit)
    function automatic row_t glyph_bits(input int k, input int c);
        int v;
        v = (k * 11 + c * 29 + 5) % (1 << N_ROWS);
        return row_t'(v);
    endfunction
endpackage

// File: rtl/glyph_rom.sv
// Glyph store: a constant array of N_CHARS x N_GCOLS rows built at
// elaboration from the package pattern, read combinationally.
// Assumes col values at or above N_GCOLS return no lit dots.
module glyph_rom
    import chgen_pkg::*;
#(
    parameter int NCH = N_CHARS,
    parameter int NGC = N_GCOLS
) (
    input  logic [CODE_W-1:0] code,
    input  col_t              col,
    output row_t              lit
);
    localparam int DEPTH = NCH * NGC;
    localparam int IDX_W = $clog2(DEPTH);

    row_t rom [DEPTH];

    // Fill each entry with its computed column pattern
    for (genvar k = 0; k < NCH; k++) begin : g_char
        for (genvar c = 0; c < NGC; c++) begin : g_col
            assign rom[k*NGC + c] = glyph_bits(k, c);
        end
    end

    logic [IDX_W-1:0] idx;

    // Static read: address from code and column
    always_comb begin
        idx = IDX_W'(code) * IDX_W'(NGC) + IDX_W'(col);
        if (col < col_t'(NGC)) lit = rom[idx];
        else                   lit = '0;
    end
endmodule

// File: rtl/col_seq.sv
// Column sequencer: steps 0..4, then the spacing column(s), then wraps.
// A restart (or reset) parks it on the final spacing column.
// Assumes step is a one-cycle synchronous enable.
module col_seq
    import chgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic restart,
    input  logic two_space,
    output col_t col,
    output logic last
);
    col_t nxt;

    // Next-column choice for an advance
    always_comb begin
        if (col == COL_LAST)                nxt = '0;
        else if (col == col_t'(N_GCOLS-1))  nxt = two_space ? COL_SP1 : COL_LAST;
        else                                nxt = col + col_t'(1);
    end

    // Column register with restart priority over step
    always_ff @(posedge clk) begin
        if (!rst_n)       col <= COL_LAST;
        else if (restart) col <= COL_LAST;
        else if (step)    col <= nxt;
    end

    assign last = (col == COL_LAST);

    // R5
    restart_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> last);
    // R2
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && last) |=> (col == '0));
    // R3
    one_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !restart && !two_space && col == col_t'(N_GCOLS-1)) |=> last);
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !restart) |=> $stable(col));
endmodule

// File: rtl/dot_out.sv
// Output stage: inverts lit dots to active-low, forces dot-off in
// spacing columns or when blanked, and releases lines when disabled.
// Assumes the released state reads as all zeros with drive low.
module dot_out
    import chgen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  row_t lit,
    input  col_t col,
    input  logic blank,
    input  logic out_en,
    output row_t dots,
    output logic drive
);
    logic spacing;

    // Output selection per column and control state
    always_comb begin
        spacing = (col >= col_t'(N_GCOLS));
        if (!out_en)                 dots = '0;
        else if (blank || spacing)   dots = '1;
        else                         dots = ~lit;
        drive = out_en;
    end

    // R7
    blank_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && blank) |-> (dots == '1));
    // R8
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (!drive && dots == '0));
endmodule

// File: rtl/charcol_gen.sv
// Top: column-scan 5x7 character generator. The glyph store feeds the
// output stage at the column chosen by the sequencer.
// Assumes synchronous active-low reset and single-cycle step pulses.
module charcol_gen
    import chgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] char_code,
    input  logic              col_step,
    input  logic              seq_restart,
    input  logic              two_space,
    input  logic              blank,
    input  logic              out_en,
    output logic [N_ROWS-1:0] dots,
    output logic              dots_drive,
    output logic              col_last
);
    col_t col;
    row_t lit;

    col_seq u_seq (
        .clk(clk), .rst_n(rst_n), .step(col_step), .restart(seq_restart),
        .two_space(two_space), .col(col), .last(col_last)
    );

    glyph_rom u_rom (.code(char_code), .col(col), .lit(lit));

    dot_out u_out (
        .clk(clk), .rst_n(rst_n), .lit(lit), .col(col), .blank(blank),
        .out_en(out_en), .dots(dots), .drive(dots_drive)
    );

    // R6
    last_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && out_en) |-> (dots == '1));
endmodule

// File: tb/sim_charcol_gen.sv
module sim_charcol_gen;
    logic clk = 0;
    logic rst_n = 0;
    logic [5:0] char_code = 0;
    logic col_step = 0, seq_restart = 0, two_space = 1, blank = 0, out_en = 1;
    logic [6:0] dots;
    logic dots_drive, col_last;

    int n_chk = 0, n_fail = 0;
    int mcol = 6;          // model column: 0..4 glyph, 5 sp1, 6 final
    bit done = 0;

    always #2.5 clk = ~clk;

    charcol_gen u0 (.*);

    function automatic logic [6:0] gpat(int k, int c);
        return 7'((k * 11 + c * 29 + 5) % 128);
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h col=%0d", tag, act, exp, mcol);
        end
    endtask

    // Compare outputs against the model for the current column
    task automatic compare(input string extra);
        logic [6:0] e;
        string tag;
        if (!out_en)              begin e = 7'h00; tag = "R8"; end
        else if (blank)           begin e = 7'h7F; tag = "R7"; end
        else if (mcol >= 5)       begin e = 7'h7F; tag = "R4"; end
        else begin e = ~gpat(char_code, mcol); tag = "R1"; end
        chk({1'b0, dots}, {1'b0, e}, {tag, extra});
        chk({7'b0, dots_drive}, {7'b0, out_en}, "R8 drive");
        chk({7'b0, col_last}, {7'b0, (mcol == 6)}, {"R6", extra});
    endtask

    // One cycle: drive inputs, check outputs, then update model at edge
    task automatic cyc(input bit st, input bit rs, input string extra);
        @(negedge clk);
        col_step = st; seq_restart = rs;
        #1 compare(extra);
        @(posedge clk);
        if (!rst_n || rs) mcol = 6;
        else if (st) begin
            if (mcol == 6)      mcol = 0;
            else if (mcol == 4) mcol = two_space ? 5 : 6;
            else                mcol = mcol + 1;
        end
    endtask

    initial begin
        cyc(0, 0, " reset");
        cyc(0, 0, " reset");
        @(negedge clk); rst_n = 1;
        #1 chk({7'b0, col_last}, 8'd1, "R11 last after reset");
        chk({1'b0, dots}, 8'h7F, "R11 dots after reset");
        // R2 R3: two spacing columns, several characters
        for (int ch = 0; ch < 3; ch++) begin
            char_code = 6'(ch * 21 + 3);
            for (int s = 0; s < 7; s++) cyc(1, 0, " R2 R3 mod7");
        end
        // R3: one spacing column
        two_space = 0;
        for (int ch = 0; ch < 3; ch++) begin
            char_code = 6'(63 - ch * 9);
            for (int s = 0; s < 6; s++) cyc(1, 0, " R3 mod6");
        end
        // R9: static read while idle
        cyc(1, 0, " step");
        cyc(1, 0, " step");
        for (int k = 0; k < 64; k += 7) begin
            char_code = 6'(k);
            cyc(0, 0, " R9 static");
        end
        // R7: blank mid-character, sequencer continues
        blank = 1;
        for (int s = 0; s < 4; s++) cyc(1, 0, " R7 blank");
        blank = 0;
        for (int s = 0; s < 3; s++) cyc(1, 0, " R7 after");
        // R8: released outputs
        out_en = 0;
        for (int s = 0; s < 3; s++) cyc(1, 0, " R8 off");
        out_en = 1;
        // R5: restart mid-character
        cyc(1, 0, " pre");
        cyc(0, 1, " R5 restart");
        cyc(1, 0, " R5 first col");
        cyc(1, 0, " R5 next");
        // R10: restart and step together
        cyc(1, 1, " R10 both");
        cyc(0, 0, " R10 parked");
        two_space = 1;
        for (int s = 0; s < 9; s++) cyc(1, 0, " R10 after");
        // mode switch while in spacing
        two_space = 0;
        for (int s = 0; s < 8; s++) cyc(1, 0, " R3 switch");
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule